// File: doc/BRIEF.md
# Two-Link Byte-Interleaved Receive Multiplexer

This block merges two E1-format receive streams, each 32 timeslots of 8 bits per 125 µs frame, onto one serial bus that runs four times as fast. The bus frame has 128 byte slots and 1024 bits. Each link is given a 2-bit channel offset. A link owns every byte slot whose slot number, taken modulo 4, equals its offset. The timeslot carried in slot `k` is `k / 4`. A 4-bit signaling word goes out on a parallel line next to the data. The signaling word is held for all eight bits of the byte it belongs to. Slots that no link owns carry idle ones.

Both links share one bit clock, one frame pulse and one set of timing controls:
- **Clock mode.** The clock runs at 1x or 2x the bit rate.
- **Edge selection.** In 2x mode, this selects which of the two clock edges of a bit updates the outputs.
- **Pulse polarity.** This sets whether the frame pulse is active high or active low.

The block presents the current timeslot number on `ts_idx`. It takes each link's byte and signaling word back in the same cycle. Frame pulses must arrive on whole-frame boundaries. Frames may be skipped. A pulse that arrives anywhere else is flagged in a sticky error and realigns the bus. When two links are given the same offset, a configuration error is raised.

Top module: `twolink_bytemux`

## Requirements
- R1: While `rst` is high, `mux_d` is 1, `mux_sig` is 4'hF, and `fp_err`, `cfg_err` and `irq` are 0.
- R2: Until the first frame pulse is taken after reset, the bus stays idle: `mux_d` = 1 and `mux_sig` = 4'hF.
- R3: Bit `j` of the frame (0..1023) belongs to slot `s = j/8`. If `s mod 4` equals `off_a`, the bit is bit `7 - (j mod 8)` of `a_data`, sampled while `ts_idx = s/4`. Link B is placed the same way using `off_b`. The most significant bit goes first.
- R4: A slot whose `s mod 4` matches neither offset drives `mux_d` = 1 and `mux_sig` = 4'hF for all eight of its bits.
- R5: In an owned slot, `mux_sig` shows the owning link's signaling word for that timeslot (`a_sig` or `b_sig`) for all eight bits.
- R6: With `mode_2x` = 0, a pulse is taken on rising edge E0, and bit `j` is driven from rising edge E(1+j). Each bit lasts one clock.
- R7: With `mode_2x` = 1, each bit lasts two clocks. With `late_edge` = 0, bit `j` is driven from edge E(1+2j). With `late_edge` = 1, it is driven from edge E(2+2j).
- R8: With `fp_inv` = 1, the frame pulse is active low on `fp_in`. With `fp_inv` = 0, it is active high.
- R9: In 2x mode, after the bus is aligned, the pulse is sampled only on the first edge of a bit. A pulse seen only on the second edge of a bit is ignored: the output sequence is unchanged and no error is flagged.
- R10: A pulse on a whole-frame boundary sets no error. This holds even after frames without a pulse, during which the bus keeps running. A pulse anywhere else sets `fp_err` and restarts the frame at bit 0.
- R11: `fp_err` stays set until `err_clr` is high on an edge that does not also set it again. `irq` goes high one clock after `fp_err` and `irq_en` are both high.
- R12: When `off_a` equals `off_b`, `cfg_err` is 1 from the next edge. Link A then owns the shared slots, and the other slots are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus bit clock (1x or 2x the bit rate) |
| rst | input | 1 | Synchronous active-high reset |
| mode_2x | input | 1 | 1: two clocks per bit |
| late_edge | input | 1 | In 2x mode, 1 updates outputs on the second edge of a bit |
| fp_inv | input | 1 | 1: frame pulse active low |
| fp_in | input | 1 | Shared frame pulse |
| off_a | input | 2 | Channel offset of link A |
| off_b | input | 2 | Channel offset of link B |
| irq_en | input | 1 | Enables the interrupt from the frame error |
| err_clr | input | 1 | Clears the sticky frame error |
| ts_idx | output | 5 | Timeslot index of the current byte slot |
| a_data | input | 8 | Link A byte for `ts_idx` |
| a_sig | input | 4 | Link A signaling for `ts_idx` |
| b_data | input | 8 | Link B byte for `ts_idx` |
| b_sig | input | 4 | Link B signaling for `ts_idx` |
| mux_d | output | 1 | Multiplexed serial data |
| mux_sig | output | 4 | Signaling aligned with the current byte |
| fp_err | output | 1 | Sticky misplaced-pulse flag |
| cfg_err | output | 1 | Equal channel offsets |
| irq | output | 1 | Interrupt request |

## Verification
Whole frames are compared bit by bit against a model under several offset pairs, including the pair (3,1). That pair shows whether the slot-to-link rule wraps correctly at the top of the group. Disjoint pairs that leave two idle slots separate the idle fill from link data. An equal pair shows the priority given to link A when slots collide.

Each clock mode and edge choice is run. In 1x mode a one-clock skew of the output is exposed. In 2x mode, a wrong hold length or the wrong edge is exposed.

The frame-pulse patterns are:
- an inverted-polarity pulse;
- frames skipped with no pulse;
- a pulse on the second half of a bit;
- a pulse in the middle of a frame.

Together these show whether free-run wrap, the sampling phase and realignment are handled correctly.

// File: rtl/mx_pkg.sv
package mx_pkg;
    localparam int LINK_N     = 2;
    localparam int GROUP_N    = 4;
    localparam int TS_N       = 32;
    localparam int BYTE_W     = 8;
    localparam int SIG_W      = 4;

    localparam int OFF_W      = $clog2(GROUP_N);
    localparam int TS_W       = $clog2(TS_N);
    localparam int SLOT_N     = TS_N * GROUP_N;
    localparam int SLOT_W     = $clog2(SLOT_N);
    localparam int BSEL_W     = $clog2(BYTE_W);
    localparam int FRAME_BITS = SLOT_N * BYTE_W;
    localparam int BCNT_W     = $clog2(FRAME_BITS);
    localparam int OWN_W      = (LINK_N > 1) ? $clog2(LINK_N) : 1;

    typedef struct packed {
        logic              synced;
        logic              half;
        logic [BCNT_W-1:0] bit_idx;
    } pos_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic [SIG_W-1:0]  sig;
    } chan_t;

    typedef struct packed {
        logic             valid;
        logic [OWN_W-1:0] link;
    } owner_t;

    localparam chan_t IDLE_CHAN = '{data: '1, sig: '1};

    function automatic logic [BCNT_W-1:0] next_bit(input logic [BCNT_W-1:0] b);
        return (b == BCNT_W'(FRAME_BITS - 1)) ? '0 : b + 1'b1;
    endfunction

    function automatic logic [BSEL_W-1:0] msb_first(input logic [BSEL_W-1:0] pos);
        return BSEL_W'(BYTE_W - 1) - pos;
    endfunction
endpackage

// File: rtl/mx_timebase.sv
module mx_timebase
    import mx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_2x,
    input  logic fp_inv,
    input  logic fp_in,
    output pos_t pos,
    output logic realign,
    output logic misalign
);
    logic fp_act;
    logic sample_ok;
    logic at_end;

    assign fp_act    = fp_in ^ fp_inv;
    assign sample_ok = !pos.synced || !mode_2x || pos.half;
    assign at_end    = (pos.bit_idx == BCNT_W'(FRAME_BITS - 1)) && (!mode_2x || pos.half);
    assign realign   = fp_act && sample_ok;
    assign misalign  = realign && pos.synced && !at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (realign) begin
            pos.synced  <= 1'b1;
            pos.half    <= 1'b0;
            pos.bit_idx <= '0;
        end else if (pos.synced) begin
            if (!mode_2x) begin
                pos.half    <= 1'b0;
                pos.bit_idx <= next_bit(pos.bit_idx);
            end else begin
                pos.half <= !pos.half;
                if (pos.half) begin
                    pos.bit_idx <= next_bit(pos.bit_idx);
                end
            end
        end
    end
endmodule

// File: rtl/mx_slotmap.sv
module mx_slotmap
    import mx_pkg::*;
(
    input  logic [SLOT_W-1:0] slot,
    input  logic [OFF_W-1:0]  off [LINK_N],
    output logic [TS_W-1:0]   ts_idx,
    output owner_t            owner,
    output logic              collide
);
    logic [OFF_W-1:0]         group_pos;
    logic [LINK_N-1:0]        hit;
    logic [LINK_N*LINK_N-1:0] pair_eq;

    assign group_pos = slot[OFF_W-1:0];
    assign ts_idx    = slot[SLOT_W-1:OFF_W];

    for (genvar l = 0; l < LINK_N; l++) begin : g_hit
        assign hit[l] = (group_pos == off[l]);
    end

    for (genvar i = 0; i < LINK_N; i++) begin : g_row
        for (genvar j = 0; j < LINK_N; j++) begin : g_col
            if (j > i) begin : g_cmp
                assign pair_eq[i*LINK_N+j] = (off[i] == off[j]);
            end else begin : g_none
                assign pair_eq[i*LINK_N+j] = 1'b0;
            end
        end
    end

    assign collide = |pair_eq;

    always_comb begin
        owner = '0;
        for (int l = LINK_N - 1; l >= 0; l--) begin
            if (hit[l]) begin
                owner.valid = 1'b1;
                owner.link  = OWN_W'(l);
            end
        end
    end
endmodule

// File: rtl/mx_serializer.sv
module mx_serializer
    import mx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_2x,
    input  logic              late_edge,
    input  logic              synced,
    input  logic              half,
    input  logic [BSEL_W-1:0] bit_pos,
    input  owner_t            owner,
    input  chan_t             chan [LINK_N],
    output logic              mux_d,
    output logic [SIG_W-1:0]  mux_sig
);
    logic  load;
    chan_t cur;

    assign load = !mode_2x || (half == late_edge);

    always_comb begin
        cur = IDLE_CHAN;
        if (synced && owner.valid) begin
            cur = chan[owner.link];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mux_d   <= 1'b1;
            mux_sig <= '1;
        end else if (load) begin
            mux_d   <= cur.data[msb_first(bit_pos)];
            mux_sig <= cur.sig;
        end
    end
endmodule

// File: rtl/mx_status.sv
module mx_status (
    input  logic clk,
    input  logic rst,
    input  logic misalign,
    input  logic err_clr,
    input  logic collide,
    input  logic irq_en,
    output logic fp_err,
    output logic cfg_err,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fp_err  <= 1'b0;
            cfg_err <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (misalign) begin
                fp_err <= 1'b1;
            end else if (err_clr) begin
                fp_err <= 1'b0;
            end
            cfg_err <= collide;
            irq     <= fp_err && irq_en;
        end
    end
endmodule

// File: rtl/twolink_bytemux.sv
module twolink_bytemux
    import mx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_2x,
    input  logic              late_edge,
    input  logic              fp_inv,
    input  logic              fp_in,
    input  logic [OFF_W-1:0]  off_a,
    input  logic [OFF_W-1:0]  off_b,
    input  logic              irq_en,
    input  logic              err_clr,
    output logic [TS_W-1:0]   ts_idx,
    input  logic [BYTE_W-1:0] a_data,
    input  logic [SIG_W-1:0]  a_sig,
    input  logic [BYTE_W-1:0] b_data,
    input  logic [SIG_W-1:0]  b_sig,
    output logic              mux_d,
    output logic [SIG_W-1:0]  mux_sig,
    output logic              fp_err,
    output logic              cfg_err,
    output logic              irq
);
    pos_t             pos;
    logic             realign;
    logic             misalign;
    logic             collide;
    owner_t           owner;
    logic [OFF_W-1:0] off  [LINK_N];
    chan_t            chan [LINK_N];

    assign off[0]  = off_a;
    assign off[1]  = off_b;
    assign chan[0] = '{data: a_data, sig: a_sig};
    assign chan[1] = '{data: b_data, sig: b_sig};

    mx_timebase u_tbase (
        .clk      (clk),
        .rst      (rst),
        .mode_2x  (mode_2x),
        .fp_inv   (fp_inv),
        .fp_in    (fp_in),
        .pos      (pos),
        .realign  (realign),
        .misalign (misalign)
    );

    mx_slotmap u_map (
        .slot    (pos.bit_idx[BCNT_W-1:BSEL_W]),
        .off     (off),
        .ts_idx  (ts_idx),
        .owner   (owner),
        .collide (collide)
    );

    mx_serializer u_ser (
        .clk       (clk),
        .rst       (rst),
        .mode_2x   (mode_2x),
        .late_edge (late_edge),
        .synced    (pos.synced),
        .half      (pos.half),
        .bit_pos   (pos.bit_idx[BSEL_W-1:0]),
        .owner     (owner),
        .chan      (chan),
        .mux_d     (mux_d),
        .mux_sig   (mux_sig)
    );

    mx_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .misalign (misalign),
        .err_clr  (err_clr),
        .collide  (collide),
        .irq_en   (irq_en),
        .fp_err   (fp_err),
        .cfg_err  (cfg_err),
        .irq      (irq)
    );
endmodule

// File: rtl/twolink_bytemux_chk.sv
module twolink_bytemux_chk
    import mx_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mode_2x,
    input logic              err_clr,
    input logic              synced,
    input logic [BCNT_W-1:0] bit_idx,
    input logic              realign,
    input logic              mux_d,
    input logic [SIG_W-1:0]  mux_sig,
    input logic              fp_err
);
    // R2
    idle_before_sync_chk: assert property (@(posedge clk) disable iff (rst)
        !synced |=> (mux_d && mux_sig == '1));

    // R6
    bit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (synced && !mode_2x && !realign) |=> bit_idx == BCNT_W'($past(bit_idx) + 1'b1));

    // R7
    two_clock_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_2x && $past(mode_2x) && !$stable(mux_d)) |=> $stable(mux_d));

    // R10
    err_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fp_err) |-> ($past(synced) && $past(realign)));

    // R11
    sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
        (fp_err && !err_clr) |=> fp_err);
endmodule

bind twolink_bytemux twolink_bytemux_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .mode_2x (mode_2x),
    .err_clr (err_clr),
    .synced  (pos.synced),
    .bit_idx (pos.bit_idx),
    .realign (realign),
    .mux_d   (mux_d),
    .mux_sig (mux_sig),
    .fp_err  (fp_err)
);

// File: tb/tb_twolink_bytemux.sv
`timescale 1ns/1ps
module tb_twolink_bytemux;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_2x = 1'b0, late_edge = 1'b0, fp_inv = 1'b0, fp_act = 1'b0;
    logic [1:0] off_a = 2'd0, off_b = 2'd1;
    logic       irq_en = 1'b0, err_clr = 1'b0;
    logic [4:0] ts_idx;
    logic [7:0] a_data, b_data;
    logic [3:0] a_sig, b_sig, mux_sig;
    logic       mux_d, fp_err, cfg_err, irq, fp_in;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int         due;
        logic       d;
        logic [3:0] s;
        string      req;
    } exp_t;
    exp_t sb[$];

    function automatic logic [7:0] dat_a(input logic [4:0] t); return 8'(t * 9 + 17);      endfunction
    function automatic logic [3:0] sig_a(input logic [4:0] t); return t[3:0];              endfunction
    function automatic logic [7:0] dat_b(input logic [4:0] t); return 8'hC3 ^ {t, 3'b101}; endfunction
    function automatic logic [3:0] sig_b(input logic [4:0] t); return ~t[3:0];             endfunction

    assign fp_in  = fp_act ^ fp_inv;
    assign a_data = dat_a(ts_idx);
    assign a_sig  = sig_a(ts_idx);
    assign b_data = dat_b(ts_idx);
    assign b_sig  = sig_b(ts_idx);

    twolink_bytemux dut (
        .clk(clk), .rst(rst), .mode_2x(mode_2x), .late_edge(late_edge), .fp_inv(fp_inv),
        .fp_in(fp_in), .off_a(off_a), .off_b(off_b), .irq_en(irq_en), .err_clr(err_clr),
        .ts_idx(ts_idx), .a_data(a_data), .a_sig(a_sig), .b_data(b_data), .b_sig(b_sig),
        .mux_d(mux_d), .mux_sig(mux_sig), .fp_err(fp_err), .cfg_err(cfg_err), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // monitor: pops expected bus bits as their sampling cycle arrives
    always @(negedge clk) begin : monitor
        exp_t it;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            it = sb.pop_front();
            if (it.due < cyc)
                chk(1'b0, it.req, "missed bus sample", 32'(it.due), 32'(cyc));
            else
                chk({mux_d, mux_sig} === {it.d, it.s}, it.req, "bus {d,sig}",
                    32'({mux_d, mux_sig}), 32'({it.d, it.s}));
        end
    end

    // driver: one frame from the current negedge; len cycles before returning
    task automatic run_frame(input bit do_pulse, input int len, input int glitch, input string req);
        int   cpb    = mode_2x ? 2 : 1;
        int   period = 1024 * cpb;
        int   c      = cyc;
        int   lim;
        int   slot, due;
        logic [4:0] ts;
        logic [7:0] byt;
        logic [3:0] sg;
        if (len == 0) len = period;
        lim = c + len + 1;
        for (int j = 0; j < 1024; j++) begin
            slot = j / 8;
            ts   = 5'(slot / 4);
            if (2'(slot % 4) == off_a)      begin byt = dat_a(ts); sg = sig_a(ts); end
            else if (2'(slot % 4) == off_b) begin byt = dat_b(ts); sg = sig_b(ts); end
            else                            begin byt = 8'hFF;     sg = 4'hF;      end
            for (int h = 0; h < cpb; h++) begin
                due = c + 2 + ((mode_2x && late_edge) ? 1 : 0) + cpb * j + h;
                if (due <= lim) sb.push_back('{due, byt[7 - (j % 8)], sg, req});
            end
        end
        fp_act = do_pulse;
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            fp_act = (i == glitch);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R3", "scoreboard drained", 32'(sb.size()), 32'd0);
    endtask

    task automatic regroup(input logic m2, input logic le, input logic inv,
                           input logic [1:0] oa, input logic [1:0] ob);
        settle();
        rst = 1'b1;
        mode_2x = m2; late_edge = le; fp_inv = inv; off_a = oa; off_b = ob;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(mux_d === 1'b1, "R1", "mux_d in reset", 32'(mux_d), 32'd1);
        chk(mux_sig === 4'hF, "R1", "mux_sig in reset", 32'(mux_sig), 32'hF);
        chk({fp_err, cfg_err, irq} === 3'b000, "R1", "flags in reset", 32'({fp_err, cfg_err, irq}), 32'd0);
        rst = 1'b0;
        // R2 idle before the first pulse
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk({mux_d, mux_sig} === 5'h1F, "R2", "idle before sync", 32'({mux_d, mux_sig}), 32'h1F);
        end

        // R3 R4 R5 R6: 1x, offsets 0/2, aligned pulses and a skipped-pulse frame
        regroup(1'b0, 1'b0, 1'b0, 2'd0, 2'd2);
        run_frame(1'b1, 0, 0, "R6");
        run_frame(1'b1, 0, 0, "R3");
        run_frame(1'b0, 0, 0, "R10");
        run_frame(1'b1, 0, 0, "R4");
        chk(fp_err === 1'b0, "R10", "no error on whole-frame pulses", 32'(fp_err), 32'd0);

        // R8: active-low pulse, offsets 3/1
        regroup(1'b0, 1'b0, 1'b1, 2'd3, 2'd1);
        run_frame(1'b1, 0, 0, "R8");
        run_frame(1'b1, 0, 0, "R5");
        chk(fp_err === 1'b0, "R8", "inverted pulse aligned", 32'(fp_err), 32'd0);

        // R7: 2x, first edge
        regroup(1'b1, 1'b0, 1'b0, 2'd1, 2'd0);
        run_frame(1'b1, 0, 0, "R7");
        run_frame(1'b1, 0, 0, "R7");

        // R7 R9: 2x, second edge, pulse on the second edge of a bit ignored
        regroup(1'b1, 1'b1, 1'b0, 2'd2, 2'd3);
        run_frame(1'b1, 0, 0, "R7");
        run_frame(1'b1, 0, 201, "R9");
        run_frame(1'b1, 0, 0, "R9");
        chk(fp_err === 1'b0, "R9", "second-edge pulse sets no error", 32'(fp_err), 32'd0);

        // R10 R11: misplaced pulse realigns and sets the sticky flag
        regroup(1'b0, 1'b0, 1'b0, 2'd0, 2'd1);
        run_frame(1'b1, 0, 0, "R10");
        run_frame(1'b1, 500, 0, "R10");
        run_frame(1'b1, 40, 0, "R10");
        chk(fp_err === 1'b1, "R10", "misplaced pulse flagged", 32'(fp_err), 32'd1);
        chk(irq === 1'b0, "R11", "irq masked", 32'(irq), 32'd0);
        irq_en = 1'b1;
        repeat (2) @(negedge clk);
        chk(irq === 1'b1, "R11", "irq enabled", 32'(irq), 32'd1);
        chk(fp_err === 1'b1, "R11", "flag sticky", 32'(fp_err), 32'd1);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(fp_err === 1'b0, "R11", "flag cleared", 32'(fp_err), 32'd0);
        repeat (2) @(negedge clk);
        chk(irq === 1'b0, "R11", "irq after clear", 32'(irq), 32'd0);
        irq_en = 1'b0;

        // R12: equal offsets
        regroup(1'b0, 1'b0, 1'b0, 2'd2, 2'd2);
        chk(cfg_err === 1'b1, "R12", "collision flagged", 32'(cfg_err), 32'd1);
        run_frame(1'b1, 0, 0, "R12");
        settle();
        off_b = 2'd0;
        repeat (2) @(negedge clk);
        chk(cfg_err === 1'b0, "R12", "collision cleared", 32'(cfg_err), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule